// File: doc/BRIEF.md
# Microcode-Partitioned Dual-Port RAM

This block is an 8 KB on-chip RAM with two ports. The system bus port reads and writes single bytes. The processor port moves 32-bit words and has two kinds of access: ordinary data reads and writes, and microcode instruction fetches.

Two configuration inputs decide which parts of the lower system RAM may hold executable microcode. The first is a 2-bit block-count selector, driven from a configuration register outside this block. The second is a high-region enable bit, held in an 8-bit control register inside this block. Every area that is opened for microcode is hidden from the system bus, together with an extension area tied to the same setting. A system-bus read of a hidden byte returns all ones. A system-bus write to a hidden byte is dropped, but the bus still sees a normal acknowledge. The top 1 KB holds peripheral parameters and is never hidden.

Microcode fetches are allowed only inside the regions currently opened for execution. A fetch at any other address returns all ones and raises an error pulse. Processor data accesses are not restricted by the lock regions.

Top module: `dpr_ucode_ram`

## Requirements
- R1: Both ports have a read latency of one clock. System byte address `4*w+k` maps to bits `[8k+7:8k]` of processor word `w`. A byte written through either port reads back through the other port.
- R2: Selector value 01 opens bytes 0x000–0x1FF for microcode. Value 10 opens 0x000–0x3FF. Value 11 opens 0x000–0x7FF. Value 00 opens no low area. Each opened area is also locked against the system bus.
- R3: With selector 01 or 10, bytes 0xF00–0xFFF are locked as well, and 0xE00–0xEFF stays open.
- R4: With selector 11, bytes 0xE00–0xFFF are locked as well.
- R5: With the high-region enable set, bytes 0x1000–0x17FF may hold microcode and are locked. Bytes 0x1800–0x19FF are also locked.
- R6: A system-bus read of a locked byte returns 0xFF. Every system-bus request, read or write, is acknowledged on the following cycle.
- R7: A system-bus write to a locked byte leaves the stored byte unchanged.
- R8: The control register resets to 0x00. Bit 7 (the most significant bit) is the high-region enable. Bits 6..0 always read as zero, whatever value was written to them.
- R9: A fetch whose address lies outside every opened microcode area returns 0xFFFFFFFF and sets `cp_fetch_err` for exactly the cycle in which that data appears. When the selector is 00 and the enable bit is 0, every fetch is refused in this way.
- R10: Bytes 0x800–0xDFF, 0x1A00–0x1BFF and 0x1C00–0x1FFF are never locked and are never valid fetch targets.
- R11: When both ports write the same byte in the same cycle, the processor port's value is stored.
- R12: Processor data reads and writes reach every address, whether or not it is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| ucode_sel | input | 2 | Block-count selector for microcode in the low area |
| cfg_we | input | 1 | Write strobe for the high-region control register |
| cfg_wdata | input | 8 | Write data for the control register |
| cfg_rdata | output | 8 | Current value of the control register |
| sys_req | input | 1 | System-bus access request |
| sys_we | input | 1 | System-bus write (1) or read (0) |
| sys_addr | input | 13 | System-bus byte address |
| sys_wdata | input | 8 | System-bus write byte |
| sys_rdata | output | 8 | System-bus read byte, valid while `sys_ack` is high |
| sys_ack | output | 1 | Acknowledge, one cycle after the request |
| cp_req | input | 1 | Processor access request |
| cp_fetch | input | 1 | Processor access is a microcode fetch |
| cp_we | input | 1 | Processor data write (ignored during a fetch) |
| cp_addr | input | 11 | Processor word address |
| cp_wdata | input | 32 | Processor write word |
| cp_rdata | output | 32 | Processor read word, one cycle after the request |
| cp_fetch_err | output | 1 | Refused fetch, aligned with its `cp_rdata` |

## Verification
The checker watches several things on every cycle:
- The reserved control bits stay at zero.
- Each system-bus request is acknowledged on the next cycle, and no acknowledge appears without a request.
- A refused fetch always carries all-ones data and always follows a real fetch request.
- Fetch permission is right for the lowest block, the high execute region, the always-open middle band and the fully disabled setting.

Whether locked bytes really read as 0xFF, keep their old contents after a discarded write, and stay unlocked at each region edge can only be shown by the bench. It compares read data against its own byte model, across random selector changes and directed probes on both sides of every boundary.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   // The array is cut into 32 equal pages (256 bytes for the default size).
   localparam int unsigned PAGE_IDX_W = 5;
   typedef logic [PAGE_IDX_W-1:0] page_t;

   typedef enum logic [1:0] {
      UC_NONE = 2'b00,
      UC_ONE  = 2'b01,
      UC_TWO  = 2'b10,
      UC_FOUR = 2'b11
   } uc_sel_e;

   // Page boundaries of the partition.
   localparam page_t PG_UC_ONE_LAST  = 5'd1;
   localparam page_t PG_UC_TWO_LAST  = 5'd3;
   localparam page_t PG_UC_FOUR_LAST = 5'd7;
   localparam page_t PG_EXT_SHORT    = 5'd15;
   localparam page_t PG_EXT_LONG_LO  = 5'd14;
   localparam page_t PG_EXT_LONG_HI  = 5'd15;
   localparam page_t PG_HI_LO        = 5'd16;
   localparam page_t PG_HI_HI        = 5'd23;
   localparam page_t PG_HIX_LO       = 5'd24;
   localparam page_t PG_HIX_HI       = 5'd25;

   typedef struct packed {
      logic locked;
      logic exec;
   } region_t;

   function automatic page_t uc_last_page(uc_sel_e s);
      case (s)
         UC_ONE:  return PG_UC_ONE_LAST;
         UC_TWO:  return PG_UC_TWO_LAST;
         UC_FOUR: return PG_UC_FOUR_LAST;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/dpr_region_decode.sv
module dpr_region_decode
   import dpr_pkg::*;
(
   input  page_t   page,
   input  uc_sel_e sel,
   input  logic    hi_en,
   output region_t info
);

   always_comb begin
      info = '0;
      // low microcode blocks: executable and hidden
      if (sel != UC_NONE && page <= uc_last_page(sel)) begin
         info.locked = 1'b1;
         info.exec   = 1'b1;
      end
      // extension tied to the low selector
      if ((sel == UC_ONE || sel == UC_TWO) && page == PG_EXT_SHORT)
         info.locked = 1'b1;
      if (sel == UC_FOUR && page >= PG_EXT_LONG_LO && page <= PG_EXT_LONG_HI)
         info.locked = 1'b1;
      // high region and its extension
      if (hi_en && page >= PG_HI_LO && page <= PG_HI_HI) begin
         info.locked = 1'b1;
         info.exec   = 1'b1;
      end
      if (hi_en && page >= PG_HIX_LO && page <= PG_HIX_HI)
         info.locked = 1'b1;
   end

endmodule

// File: rtl/dpr_cfg_reg.sv
module dpr_cfg_reg #(
   parameter int unsigned REG_W  = 8,
   parameter int unsigned EN_BIT = REG_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             hi_en
);

   generate
      if (EN_BIT >= REG_W) begin : g_bad_bit
         $error("dpr_cfg_reg: EN_BIT outside register");
      end
   endgenerate

   logic en_q;
   logic rsvd_unused;

   // Only the enable bit is stored; reserved bits have no flops.
   assign rsvd_unused = ^(wdata & ~(REG_W'(1) << EN_BIT));

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (we)
         en_q <= wdata[EN_BIT];
   end

   always_comb begin
      rdata         = '0;
      rdata[EN_BIT] = en_q;
   end

   assign hi_en = en_q;

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
   parameter  int unsigned WORD_BYTES = 4,
   parameter  int unsigned DEPTH      = 2048,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned WORD_W     = 8 * WORD_BYTES
) (
   input  logic                  clk,
   // port A: word-wide, wins on conflict
   input  logic                  a_we,
   input  logic [AW-1:0]         a_addr,
   input  logic [WORD_W-1:0]     a_wdata,
   output logic [WORD_W-1:0]     a_rdata,
   // port B: per-lane write enables
   input  logic [WORD_BYTES-1:0] b_wen,
   input  logic [AW-1:0]         b_addr,
   input  logic [WORD_W-1:0]     b_wdata,
   output logic [WORD_W-1:0]     b_rdata
);

   generate
      for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
         logic [7:0] store [DEPTH];
         logic [7:0] a_q;
         logic [7:0] b_q;

         always_ff @(posedge clk) begin
            if (b_wen[k])
               store[b_addr] <= b_wdata[8*k +: 8];
            // later assignment wins a same-address collision
            if (a_we)
               store[a_addr] <= a_wdata[8*k +: 8];
            a_q <= store[a_addr];
            b_q <= store[b_addr];
         end

         assign a_rdata[8*k +: 8] = a_q;
         assign b_rdata[8*k +: 8] = b_q;
      end
   endgenerate

endmodule

// File: rtl/dpr_ucode_ram.sv
module dpr_ucode_ram
   import dpr_pkg::*;
#(
   parameter  int unsigned MEM_BYTES  = 8192,
   parameter  int unsigned WORD_BYTES = 4,
   parameter  int unsigned CFG_W      = 8,
   localparam int unsigned SYS_AW     = $clog2(MEM_BYTES),
   localparam int unsigned LANE_W     = $clog2(WORD_BYTES),
   localparam int unsigned CP_AW      = SYS_AW - LANE_W,
   localparam int unsigned WORD_W     = 8 * WORD_BYTES,
   localparam int unsigned DEPTH      = MEM_BYTES / WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ucode_sel,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              sys_req,
   input  logic              sys_we,
   input  logic [SYS_AW-1:0] sys_addr,
   input  logic [7:0]        sys_wdata,
   output logic [7:0]        sys_rdata,
   output logic              sys_ack,
   input  logic              cp_req,
   input  logic              cp_fetch,
   input  logic              cp_we,
   input  logic [CP_AW-1:0]  cp_addr,
   input  logic [WORD_W-1:0] cp_wdata,
   output logic [WORD_W-1:0] cp_rdata,
   output logic              cp_fetch_err
);

   // elaboration-time parameter checks
   generate
      if ((1 << SYS_AW) != MEM_BYTES) begin : g_bad_size
         $error("dpr_ucode_ram: MEM_BYTES must be a power of two");
      end
      if (WORD_BYTES < 2 || (1 << LANE_W) != WORD_BYTES) begin : g_bad_word
         $error("dpr_ucode_ram: WORD_BYTES must be a power of two >= 2");
      end
      if (CP_AW < PAGE_IDX_W) begin : g_bad_pages
         $error("dpr_ucode_ram: array too small for the page partition");
      end
      if (CFG_W < 2) begin : g_bad_cfg
         $error("dpr_ucode_ram: CFG_W too narrow");
      end
   endgenerate

   uc_sel_e sel;
   assign sel = uc_sel_e'(ucode_sel);

   // control register
   logic hi_en;
   dpr_cfg_reg #(.REG_W(CFG_W)) cfg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .hi_en (hi_en)
   );

   // region decode, one per port
   page_t   sys_page, cp_page;
   region_t sys_info, cp_info;
   assign sys_page = sys_addr[SYS_AW-1 -: PAGE_IDX_W];
   assign cp_page  = cp_addr[CP_AW-1 -: PAGE_IDX_W];

   dpr_region_decode sys_dec_i (.page(sys_page), .sel(sel), .hi_en(hi_en), .info(sys_info));
   dpr_region_decode cp_dec_i  (.page(cp_page),  .sel(sel), .hi_en(hi_en), .info(cp_info));

   // system-bus write gating
   logic [LANE_W-1:0]     sys_lane;
   logic [CP_AW-1:0]      sys_word;
   logic                  sys_wr_ok;
   logic [WORD_BYTES-1:0] sys_wen;

   assign sys_lane  = sys_addr[LANE_W-1:0];
   assign sys_word  = sys_addr[SYS_AW-1:LANE_W];
   assign sys_wr_ok = sys_req & sys_we & ~sys_info.locked;

   generate
      for (genvar k = 0; k < WORD_BYTES; k++) begin : g_wen
         assign sys_wen[k] = sys_wr_ok && (sys_lane == LANE_W'(k));
      end
   endgenerate

   // processor side
   logic cp_wr, fetch_bad;
   assign cp_wr     = cp_req & cp_we & ~cp_fetch;
   assign fetch_bad = cp_req & cp_fetch & ~cp_info.exec;

   logic [WORD_W-1:0] a_rdata, b_rdata;

   dpr_array #(.WORD_BYTES(WORD_BYTES), .DEPTH(DEPTH)) array_i (
      .clk     (clk),
      .a_we    (cp_wr),
      .a_addr  (cp_addr),
      .a_wdata (cp_wdata),
      .a_rdata (a_rdata),
      .b_wen   (sys_wen),
      .b_addr  (sys_word),
      .b_wdata ({WORD_BYTES{sys_wdata}}),
      .b_rdata (b_rdata)
   );

   // response pipeline, aligned with the array read register
   logic              sys_ack_q, sys_lock_q, cp_err_q;
   logic [LANE_W-1:0] sys_lane_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sys_ack_q  <= 1'b0;
         sys_lock_q <= 1'b0;
         sys_lane_q <= '0;
         cp_err_q   <= 1'b0;
      end else begin
         sys_ack_q  <= sys_req;
         sys_lock_q <= sys_req & sys_info.locked;
         sys_lane_q <= sys_lane;
         cp_err_q   <= fetch_bad;
      end
   end

   assign sys_ack      = sys_ack_q;
   assign sys_rdata    = sys_lock_q ? 8'hFF : b_rdata[{sys_lane_q, 3'b000} +: 8];
   assign cp_rdata     = cp_err_q ? '1 : a_rdata;
   assign cp_fetch_err = cp_err_q;

endmodule

// File: rtl/dpr_ucode_ram_chk.sv
module dpr_ucode_ram_chk #(
   parameter int unsigned CP_AW  = 11,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned CFG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        ucode_sel,
   input logic [CFG_W-1:0]  cfg_rdata,
   input logic              sys_req,
   input logic              sys_ack,
   input logic              cp_req,
   input logic              cp_fetch,
   input logic [CP_AW-1:0]  cp_addr,
   input logic [WORD_W-1:0] cp_rdata,
   input logic              cp_fetch_err
);

   logic [4:0] pg;
   logic       hi;
   assign pg = cp_addr[CP_AW-1 -: 5];
   assign hi = cfg_rdata[CFG_W-1];

   a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[CFG_W-2:0] == '0);

   a_r6_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      sys_req |=> sys_ack);

   a_r6_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      sys_ack |-> $past(sys_req));

   a_r9_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
      cp_fetch_err |-> (cp_rdata == '1));

   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cp_fetch_err |-> $past(cp_req && cp_fetch));

   a_r9_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && cp_fetch && ucode_sel == 2'b00 && !hi) |=> cp_fetch_err);

   a_r2_first_block: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && cp_fetch && ucode_sel != 2'b00 && pg < 5'd2) |=> !cp_fetch_err);

   a_r5_high_exec: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && cp_fetch && hi && pg >= 5'd16 && pg <= 5'd23) |=> !cp_fetch_err);

   a_r10_open_band: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && cp_fetch && pg >= 5'd8 && pg <= 5'd13) |=> cp_fetch_err);

endmodule

bind dpr_ucode_ram dpr_ucode_ram_chk #(
   .CP_AW(CP_AW), .WORD_W(WORD_W), .CFG_W(CFG_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ucode_sel    (ucode_sel),
   .cfg_rdata    (cfg_rdata),
   .sys_req      (sys_req),
   .sys_ack      (sys_ack),
   .cp_req       (cp_req),
   .cp_fetch     (cp_fetch),
   .cp_addr      (cp_addr),
   .cp_rdata     (cp_rdata),
   .cp_fetch_err (cp_fetch_err)
);

// File: tb/dpr_ucode_ram_tb.sv
module dpr_ucode_ram_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ucode_sel = 2'b00;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        sys_req = 1'b0, sys_we = 1'b0;
   logic [12:0] sys_addr = '0;
   logic [7:0]  sys_wdata = '0;
   logic [7:0]  sys_rdata;
   logic        sys_ack;
   logic        cp_req = 1'b0, cp_fetch = 1'b0, cp_we = 1'b0;
   logic [10:0] cp_addr = '0;
   logic [31:0] cp_wdata = '0;
   logic [31:0] cp_rdata;
   logic        cp_fetch_err;

   always #5 clk = ~clk;

   dpr_ucode_ram dut_i (.*);

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   logic [31:0] model [0:2047];
   bit hi_m = 0;

   function automatic bit in_low(int p, logic [1:0] s);
      int lim;
      lim = (s == 2'b01) ? 1 : (s == 2'b10) ? 3 : 7;
      return (s != 2'b00) && (p <= lim);
   endfunction

   function automatic bit locked_f(int a, logic [1:0] s, bit h);
      int p;
      p = a >> 8;
      if (in_low(p, s)) return 1;
      if ((s == 2'b01 || s == 2'b10) && p == 15) return 1;
      if (s == 2'b11 && (p == 14 || p == 15)) return 1;
      if (h && p >= 16 && p <= 25) return 1;
      return 0;
   endfunction

   function automatic bit exec_f(int w, logic [1:0] s, bit h);
      int p;
      p = w >> 6;
      return in_low(p, s) || (h && p >= 16 && p <= 23);
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sys_rd(int a, string req);
      logic [7:0] exp;
      @(negedge clk);
      sys_req = 1; sys_we = 0; sys_addr = 13'(a);
      @(negedge clk);
      sys_req = 0;
      exp = locked_f(a, ucode_sel, hi_m) ? 8'hFF : model[a >> 2][8*(a % 4) +: 8];
      check(sys_ack === 1'b1 && sys_rdata === exp, req, {23'd0, sys_ack, sys_rdata}, {24'd1, exp});
   endtask

   task automatic sys_wr(int a, logic [7:0] d, string req);
      @(negedge clk);
      sys_req = 1; sys_we = 1; sys_addr = 13'(a); sys_wdata = d;
      @(negedge clk);
      sys_req = 0; sys_we = 0;
      check(sys_ack === 1'b1, req, {31'd0, sys_ack}, 32'd1);
      if (!locked_f(a, ucode_sel, hi_m)) model[a >> 2][8*(a % 4) +: 8] = d;
   endtask

   task automatic cp_wr(int w, logic [31:0] d);
      @(negedge clk);
      cp_req = 1; cp_we = 1; cp_fetch = 0; cp_addr = 11'(w); cp_wdata = d;
      @(negedge clk);
      cp_req = 0; cp_we = 0;
      model[w] = d;
   endtask

   task automatic cp_rd(int w, bit fetch, string req);
      logic [31:0] exp;
      bit          eerr;
      @(negedge clk);
      cp_req = 1; cp_we = fetch; cp_fetch = fetch; cp_addr = 11'(w);
      @(negedge clk);
      cp_req = 0; cp_we = 0; cp_fetch = 0;
      eerr = fetch && !exec_f(w, ucode_sel, hi_m);
      exp  = eerr ? 32'hFFFF_FFFF : model[w];
      check(cp_rdata === exp, req, cp_rdata, exp);
      check(cp_fetch_err === eerr, req, {31'd0, cp_fetch_err}, {31'd0, eerr});
   endtask

   task automatic cfg_wr(logic [7:0] d, string req);
      @(negedge clk);
      cfg_we = 1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
      hi_m = d[7];
      check(cfg_rdata === {d[7], 7'd0}, req, {24'd0, cfg_rdata}, {24'd0, d[7], 7'd0});
   endtask

   task automatic collide(int w, int lane, logic [7:0] sd, logic [31:0] cd);
      @(negedge clk);
      cp_req = 1; cp_we = 1; cp_fetch = 0; cp_addr = 11'(w); cp_wdata = cd;
      sys_req = 1; sys_we = 1; sys_addr = 13'(w * 4 + lane); sys_wdata = sd;
      @(negedge clk);
      cp_req = 0; cp_we = 0; sys_req = 0; sys_we = 0;
      model[w] = cd;
      cp_rd(w, 0, "R11 processor wins collision");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state (R8, R6, R9)
      check(cfg_rdata === 8'h00, "R8 reset value", {24'd0, cfg_rdata}, 32'd0);
      check(sys_ack === 1'b0, "R6 no ack after reset", {31'd0, sys_ack}, 32'd0);
      check(cp_fetch_err === 1'b0, "R9 no err after reset", {31'd0, cp_fetch_err}, 32'd0);

      // preload through the processor data port
      for (int w = 0; w < 2048; w++) cp_wr(w, $urandom);

      // R1 lane mapping and cross-port read
      cp_wr(700, 32'hA1B2C3D4);
      sys_rd(2800, "R1 lane0"); sys_rd(2803, "R1 lane3");
      sys_wr(2801, 8'h5E, "R1 sys write ack");
      cp_rd(700, 0, "R1 cross-port readback");

      // R8 control register
      cfg_wr(8'hFF, "R8 enable with reserved set");
      cfg_wr(8'h7F, "R8 reserved only");

      // R9 everything disabled
      ucode_sel = 2'b00;
      cp_rd(0, 1, "R9 fetch all disabled");
      cp_rd(1800, 1, "R9 fetch high disabled");

      // R2 / R3 selector 01 and 10
      ucode_sel = 2'b01;
      cp_rd(127, 1, "R2 sel01 last word"); cp_rd(128, 1, "R2 sel01 beyond");
      sys_rd(16'h1FF, "R2 sel01 locked"); sys_rd(16'h200, "R2 sel01 open");
      sys_rd(16'hF00, "R3 ext locked"); sys_rd(16'hEFF, "R3 below ext open");
      ucode_sel = 2'b10;
      cp_rd(255, 1, "R2 sel10 last word"); cp_rd(256, 1, "R2 sel10 beyond");
      sys_rd(16'h3FF, "R2 sel10 locked"); sys_rd(16'hFFF, "R3 sel10 ext");
      sys_rd(16'hEFF, "R3 sel10 below ext");

      // R4 selector 11
      ucode_sel = 2'b11;
      sys_rd(16'h7FF, "R4 low locked"); sys_rd(16'h800, "R10 open band");
      sys_rd(16'hDFF, "R4 below ext open"); sys_rd(16'hE00, "R4 ext locked");
      cp_rd(511, 1, "R2 sel11 last word"); cp_rd(512, 1, "R10 no fetch in band");

      // R7 locked write discarded, then visible unlocked
      sys_wr(16'hE10, 8'h3C, "R7 locked write ack");
      ucode_sel = 2'b00;
      sys_rd(16'hE10, "R7 contents kept");

      // R5 high region
      cfg_wr(8'h80, "R8 enable high");
      cp_rd(16'h17FF >> 2, 1, "R5 high last word"); cp_rd(16'h1000 >> 2, 1, "R5 high first word");
      cp_rd(16'h1800 >> 2, 1, "R5 ext not executable");
      sys_rd(16'h17FF, "R5 high locked"); sys_rd(16'h19FF, "R5 ext locked");
      sys_rd(16'h1A00, "R10 gap open"); sys_rd(16'h1C00, "R10 param open");
      sys_rd(16'h1FFF, "R10 param top open");
      cp_rd(16'h1C00 >> 2, 1, "R10 no fetch in param");
      // R12 data access to locked area
      cp_wr(16'h1900 >> 2, 32'hCAFEF00D);
      cp_rd(16'h1900 >> 2, 0, "R12 data read of locked word");

      // R11 collisions
      collide(40, 2, 8'h11, 32'h55667788);
      collide(1900, 0, 8'h22, 32'h01020304);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 4)       cfg_wr(8'($urandom), "R8 random write");
         else if (r < 10) ucode_sel = 2'($urandom);
         else if (r < 35) sys_rd($urandom_range(0, 8191), "R6 random sys read");
         else if (r < 55) sys_wr($urandom_range(0, 8191), 8'($urandom), "R7 random sys write");
         else if (r < 63) cp_wr($urandom_range(0, 2047), $urandom);
         else if (r < 73) cp_rd($urandom_range(0, 2047), 0, "R12 random data read");
         else if (r < 94) cp_rd($urandom_range(0, 2047), 1, "R9 random fetch");
         else             collide($urandom_range(0, 2047), $urandom_range(0, 3), 8'($urandom), $urandom);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule